// File: doc/BRIEF.md
# Modulo-Loop Branch Controller

This block makes the loop-closing branch decision for software-pipelined loops. It keeps a 64-bit trip counter and a 6-bit drain counter. Each loop-branch request consumes one count and rotates the register bases. It also pushes a stage-enable bit into a bank of rotating predicates. Software loads the trip counter with the iteration count minus one and the drain counter with the number of pipeline stages. It then clears the predicates, which also seeds the lowest rotating one. One loop body now runs the prologue, the kernel and the epilogue with no separate code copies. Stages guarded by higher predicates switch on one iteration apart while the pipeline fills, and switch off one iteration apart while it drains.

A request is resolved in one of three ways, and a four-state machine records which one. The states are ST_IDLE (no request was taken last cycle), ST_KERNEL (trip counter was nonzero), ST_DRAIN (trip counter zero, drain counter above one) and ST_EXIT (trip counter zero, drain counter one or zero). An accepted request moves the machine from any state to ST_KERNEL, ST_DRAIN or ST_EXIT, according to the counters. A cycle without an accepted request returns it to ST_IDLE. The outputs are decoded from the state, so they appear one cycle after the request. The counters and predicates update on the same edge.

Top module: `mlb_ctrl`

## Requirements
- R1: After reset br_taken and rot_stb are 0, pred equals 64'h1 (only p0 set), and both counters are 0.
- R2: pred[0] reads 1 at all times. A pred_clear makes pred equal 64'h10001 on the next cycle, with only p0 and p16 set.
- R3: An accepted request with a nonzero trip counter gives br_taken=1 and rot_stb=1 on the next cycle. On the same edge the trip counter decrements and p16 becomes 1.
- R4: An accepted request with a zero trip counter and a drain counter above 1 gives br_taken=1 and rot_stb=1 on the next cycle. On the same edge the drain counter decrements and p16 becomes 0.
- R5: An accepted request with a zero trip counter and a drain counter of 1 or 0 gives br_taken=0 and rot_stb=1 on the next cycle. On the same edge p16 becomes 0 and the drain counter decrements, staying at 0 if it was already 0.
- R6: On every accepted request, for i = 16 to 62, the new p(i+1) equals the old p(i). The old p63 is dropped, and p1 to p15 keep their values.
- R7: rot_stb is 1 for exactly the cycle after each accepted request and 0 in every other cycle. br_taken is never 1 while rot_stb is 0.
- R8: A br_req in the same cycle as lc_wr, ec_wr or pred_clear is not accepted. There is no strobe and no rotation, and the written value takes effect.
- R9: After trip counter L and drain counter E are loaded, successive requests give L + max(E-1,0) taken branches and then one fall-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lc_wr | input | 1 | Load the trip counter |
| lc_wdata | input | 64 | Trip counter load value |
| ec_wr | input | 1 | Load the drain counter |
| ec_wdata | input | 6 | Drain counter load value |
| pred_clear | input | 1 | Clear the predicates and set p16 |
| br_req | input | 1 | Loop-branch request strobe |
| br_taken | output | 1 | The last request branched back |
| rot_stb | output | 1 | Rotate strobe to the rotating register files |
| pred | output | 64 | Predicate vector, p0 at bit 0 |

## Verification
The hardest condition to reach is the point where the trip counter has just run out and the drain counter decides between one more taken drain step and the final fall-through. Reaching it through the ports takes a full loop run. The bench therefore loads random small trip and drain counts, including drain counts of 0 and 1, and steps each loop to its exit with random idle gaps between requests. Every outcome and the predicate vector are compared with a bench model. Directed cases add a maximal trip count, extra requests after exit to exercise drain saturation, and a request that collides with a register write.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_KERNEL,
        ST_DRAIN,
        ST_EXIT
    } br_state_e;
endpackage

// File: rtl/mlb_counters.sv
module mlb_counters #(
    parameter int LC_W = 64,
    parameter int EC_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lc_wr,
    input  logic [LC_W-1:0] lc_wdata,
    input  logic            ec_wr,
    input  logic [EC_W-1:0] ec_wdata,
    input  logic            lc_dec,
    input  logic            ec_dec,
    output logic [LC_W-1:0] lc,
    output logic [EC_W-1:0] ec
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc <= '0;
        end else if (lc_wr) begin
            lc <= lc_wdata;
        end else if (lc_dec) begin
            lc <= lc - LC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ec <= '0;
        end else if (ec_wr) begin
            ec <= ec_wdata;
        end else if (ec_dec && ec != '0) begin
            ec <= ec - EC_W'(1);
        end
    end

    // R5: drain counter never wraps below zero
    p_ec_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ec_dec && !ec_wr && ec == '0) |=> ec == '0);

    // R3: trip counter steps down by one per kernel step
    p_lc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_dec && !lc_wr) |=> lc == $past(lc) - LC_W'(1));
endmodule

// File: rtl/mlb_pred_bank.sv
module mlb_pred_bank #(
    parameter int NPRED  = 64,
    parameter int ROT_LO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             inject,
    output logic [NPRED-1:0] pred
);
    for (genvar i = 0; i < NPRED; i++) begin : g_bit
        if (i == 0) begin : g_true
            assign pred[i] = 1'b1;
        end else if (i < ROT_LO) begin : g_static
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n || clear) q <= 1'b0;
            end
            assign pred[i] = q;
        end else if (i == ROT_LO) begin : g_head
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= 1'b0;
                else if (clear) q <= 1'b1;
                else if (shift) q <= inject;
            end
            assign pred[i] = q;
        end else begin : g_rot
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n || clear) q <= 1'b0;
                else if (shift)      q <= pred[i-1];
            end
            assign pred[i] = q;
        end
    end

    // R6: rotating section moves up by one position per shift
    p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clear) |=> pred[NPRED-1:ROT_LO+1] == $past(pred[NPRED-2:ROT_LO]));

    // R6: static section untouched by a shift
    p_static_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clear) |=> pred[ROT_LO-1:0] == $past(pred[ROT_LO-1:0]));
endmodule

// File: rtl/mlb_ctrl.sv
module mlb_ctrl
    import mlb_pkg::*;
#(
    parameter int LC_W  = 64,
    parameter int EC_W  = 6,
    parameter int NPRED = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lc_wr,
    input  logic [LC_W-1:0]  lc_wdata,
    input  logic             ec_wr,
    input  logic [EC_W-1:0]  ec_wdata,
    input  logic             pred_clear,
    input  logic             br_req,
    output logic             br_taken,
    output logic             rot_stb,
    output logic [NPRED-1:0] pred
);
    localparam int ROT_LO = NPRED / 4;

    br_state_e       state, state_nxt;
    logic [LC_W-1:0] lc;
    logic [EC_W-1:0] ec;
    logic            accept, lc_nz;

    assign accept = br_req && !lc_wr && !ec_wr && !pred_clear;
    assign lc_nz  = (lc != '0);

    mlb_counters #(.LC_W(LC_W), .EC_W(EC_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .lc_wr    (lc_wr),
        .lc_wdata (lc_wdata),
        .ec_wr    (ec_wr),
        .ec_wdata (ec_wdata),
        .lc_dec   (accept && lc_nz),
        .ec_dec   (accept && !lc_nz),
        .lc       (lc),
        .ec       (ec)
    );

    mlb_pred_bank #(.NPRED(NPRED), .ROT_LO(ROT_LO)) u_pred (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pred_clear),
        .shift  (accept),
        .inject (lc_nz),
        .pred   (pred)
    );

    always_comb begin
        state_nxt = ST_IDLE;
        if (accept) begin
            if (lc_nz)                 state_nxt = ST_KERNEL;
            else if (ec > EC_W'(1))    state_nxt = ST_DRAIN;
            else                       state_nxt = ST_EXIT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   begin br_taken = 1'b0; rot_stb = 1'b0; end
            ST_KERNEL: begin br_taken = 1'b1; rot_stb = 1'b1; end
            ST_DRAIN:  begin br_taken = 1'b1; rot_stb = 1'b1; end
            ST_EXIT:   begin br_taken = 1'b0; rot_stb = 1'b1; end
            default:   begin br_taken = 1'b0; rot_stb = 1'b0; end
        endcase
    end

    // R3: kernel step injects a one
    p_kernel_inject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KERNEL) |-> pred[ROT_LO]);

    // R4: drain and exit steps inject a zero
    p_drain_inject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN || state == ST_EXIT) |-> !pred[ROT_LO]);

    // R2: p0 constant true
    p_p0_true_r2: assert property (@(posedge clk) disable iff (!rst_n) pred[0]);

    // R7: strobe follows exactly the accepted requests
    p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rot_stb);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rot_stb);
    p_taken_implies_rot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> rot_stb);

    // R8: colliding request causes no rotation
    p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && (lc_wr || ec_wr) && !pred_clear) |=> (!rot_stb && $stable(pred)));
endmodule

// File: tb/mlb_ctrl_tb_top.sv
module mlb_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lc_wr = 1'b0;
    logic [63:0] lc_wdata = '0;
    logic        ec_wr = 1'b0;
    logic [5:0]  ec_wdata = '0;
    logic        pred_clear = 1'b0;
    logic        br_req = 1'b0;
    logic        br_taken, rot_stb;
    logic [63:0] pred;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] m_lc;
    logic [5:0]  m_ec;
    logic [63:0] m_pred;

    always #5 clk = ~clk;

    mlb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .lc_wr(lc_wr), .lc_wdata(lc_wdata),
        .ec_wr(ec_wr), .ec_wdata(ec_wdata), .pred_clear(pred_clear),
        .br_req(br_req), .br_taken(br_taken), .rot_stb(rot_stb), .pred(pred)
    );

    // 0 kernel, 1 drain, 2 exit
    function automatic int kind_of(logic [63:0] lc, logic [5:0] ec);
        if (lc != 0)     return 0;
        else if (ec > 1) return 1;
        else             return 2;
    endfunction

    function automatic logic [63:0] rotate(logic [63:0] p, logic b);
        logic [63:0] r;
        r = p;
        r[63:17] = p[62:16];
        r[16] = b;
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_lc(logic [63:0] v);
        lc_wr = 1'b1; lc_wdata = v;
        @(negedge clk);
        lc_wr = 1'b0;
        m_lc = v;
    endtask

    task automatic wr_ec(logic [5:0] v);
        ec_wr = 1'b1; ec_wdata = v;
        @(negedge clk);
        ec_wr = 1'b0;
        m_ec = v;
    endtask

    task automatic clr();
        pred_clear = 1'b1;
        @(negedge clk);
        pred_clear = 1'b0;
        m_pred = 64'h10001;
        chk("R2 clear", pred, 64'h10001);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R7 idle strobe", {63'd0, rot_stb}, 64'd0);
        end
    endtask

    // returns 1 if taken
    task automatic do_req(output bit taken);
        int k;
        k = kind_of(m_lc, m_ec);
        br_req = 1'b1;
        @(negedge clk);
        br_req = 1'b0;
        m_pred = rotate(m_pred, k == 0);
        if (k == 0) m_lc = m_lc - 1;
        else if (m_ec != 0) m_ec = m_ec - 1;
        taken = (k != 2);
        case (k)
            0: chk("R3 kernel taken", {63'd0, br_taken}, 64'd1);
            1: chk("R4 drain taken", {63'd0, br_taken}, 64'd1);
            default: chk("R5 exit fallthrough", {63'd0, br_taken}, 64'd0);
        endcase
        chk("R7 strobe", {63'd0, rot_stb}, 64'd1);
        chk("R6 pred rotate", pred, m_pred);
        chk("R2 p0", {63'd0, pred[0]}, 64'd1);
    endtask

    task automatic run_loop(logic [63:0] l, logic [5:0] e, bit do_clr, bit gaps);
        bit t;
        int taken_cnt = 0;
        int exp_cnt;
        wr_lc(l);
        wr_ec(e);
        if (do_clr) clr();
        exp_cnt = int'(l) + ((e > 1) ? int'(e) - 1 : 0);
        t = 1'b1;
        while (t) begin
            do_req(t);
            if (t) taken_cnt++;
            if (gaps && ($urandom_range(0, 3) == 0)) idle($urandom_range(1, 3));
        end
        chk("R9 loop length", 64'(taken_cnt), 64'(exp_cnt));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit t;
        void'($urandom(32'd4711));
        m_lc = '0; m_ec = '0; m_pred = 64'h1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset taken", {63'd0, br_taken}, 64'd0);
        chk("R1 reset strobe", {63'd0, rot_stb}, 64'd0);
        chk("R1 reset pred", pred, 64'h1);
        // R1: counters zero -> request exits at once
        do_req(t);
        chk("R1 reset counters exit", {63'd0, t}, 64'd0);
        idle(2);

        // R2/R3/R4/R5 directed loop: 3 iterations, 3 stages
        run_loop(64'd2, 6'd3, 1'b1, 1'b0);
        idle(1);
        // R5: drain counter saturates at zero, further requests fall through
        do_req(t);
        do_req(t);
        chk("R5 saturate exit", {63'd0, t}, 64'd0);
        idle(1);
        // R5: drain counter of 1
        run_loop(64'd0, 6'd1, 1'b1, 1'b0);
        // R3: maximal trip count
        wr_lc(64'hFFFF_FFFF_FFFF_FFFF);
        do_req(t);
        chk("R3 max lc taken", {63'd0, t}, 64'd1);
        idle(1);

        // R8: request colliding with a trip counter write is ignored
        lc_wr = 1'b1; lc_wdata = 64'd3; br_req = 1'b1;
        @(negedge clk);
        lc_wr = 1'b0; br_req = 1'b0; m_lc = 64'd3;
        chk("R8 collide strobe", {63'd0, rot_stb}, 64'd0);
        chk("R8 collide pred", pred, m_pred);
        // R8: request colliding with clear is ignored
        pred_clear = 1'b1; br_req = 1'b1;
        @(negedge clk);
        pred_clear = 1'b0; br_req = 1'b0; m_pred = 64'h10001;
        chk("R8 clear collide strobe", {63'd0, rot_stb}, 64'd0);
        chk("R8 clear collide pred", pred, 64'h10001);
        wr_ec(6'd2);
        t = 1'b1;
        begin
            int cnt = 0;
            while (t) begin do_req(t); if (t) cnt++; end
            chk("R8 written lc took effect", 64'(cnt), 64'd4);
        end
        idle(1);

        // constrained random loops
        for (int r = 0; r < 60; r++) begin
            run_loop(64'($urandom_range(0, 12)), 6'($urandom_range(0, 7)),
                     $urandom_range(0, 4) != 0, 1'b1);
            idle($urandom_range(0, 2));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule